// File: doc/BRIEF.md
# Byte FIFO Pair with Watermark Interrupts

This block holds the data path of a bus master controller: one byte FIFO carries bytes from software towards the transfer engine, and a second carries received bytes back to software. A direction input selects which of the two FIFOs feeds the fill-level output and the level-derived events. Software drains the receive side by reading the level and then popping exactly that many bytes. Before each receive transfer it programs the high watermark to the smaller of the remaining length and the FIFO depth.

Both FIFOs feed an interrupt status register whose bits are cleared by writing ones. Bits latch when a condition goes from false to true: the FIFO is empty, the FIFO is full, the FIFO is at or above the high watermark, or one of five events arrives from the transfer engine. An enable register masks the status bits, and the enabled bits are ORed into one interrupt line. A control write sets both watermarks. The same write can also empty both FIFOs ahead of a new transfer.

Top module: `fifo_wmark_irq`

## Requirements
- R1: Each FIFO holds up to 128 bytes in arrival order, and its head output shows the oldest byte while the FIFO is not empty.
- R2: A push into a full FIFO and a pop from an empty FIFO are ignored. The fill level and the head byte stay as they were. On a simultaneous push and pop into a full FIFO, only the pop takes effect.
- R3: `fifo_level` shows the fill count (0 to 128) of the receive FIFO when `rd_mode` is 1 and of the transmit FIFO when it is 0. The count updates one cycle after a push or pop.
- R4: A control write loads the high watermark from `ctl_wdata[15:8]` and the low watermark from `ctl_wdata[7:0]`, and both read back on `ctl_thr` in the same positions. When bit 16 of the write is set, both FIFOs are empty in the next cycle and any push in the write cycle is dropped.
- R5: The status bits are placed as follows: address not acknowledged 25, address acknowledged 13, data done 12, arbitration lost 11, FIFO full 4, FIFO empty 3, FIFO at or above high watermark 2, bus error 0. All other bits read 0.
- R6: A status bit sets one cycle after its condition changes from false to true, whether or not it is enabled. A condition that is already true in the first cycle after reset counts as a rise. A condition that stays true does not set the bit again after it has been cleared.
- R7: For the selected FIFO, the full condition is level = 128, the empty condition is level = 0, and the high condition is level >= high watermark.
- R8: A clear write removes every status bit that is 1 in `ist_clr_data`. Writing back the value just read therefore clears exactly the bits that were observed.
- R9: When a bit's condition rises in the same cycle that a clear write names that bit, the bit stays set.
- R10: `irq` is 1 exactly when some status bit and the same enable bit are both 1. An enable write keeps only the implemented bit positions.
- R11: Synchronous reset empties both FIFOs and clears the status bits, the enable bits and the edge history. The watermarks become high = 128 and low = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_mode | input | 1 | 1 selects the receive FIFO for level and events, 0 the transmit FIFO |
| tx_push | input | 1 | Software writes a byte into the transmit FIFO |
| tx_wdata | input | 8 | Byte pushed into the transmit FIFO |
| tx_pop | input | 1 | Engine takes the head byte of the transmit FIFO |
| tx_rdata | output | 8 | Head byte of the transmit FIFO |
| rx_push | input | 1 | Engine writes a received byte |
| rx_wdata | input | 8 | Byte pushed into the receive FIFO |
| rx_pop | input | 1 | Software takes the head byte of the receive FIFO |
| rx_rdata | output | 8 | Head byte of the receive FIFO |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 17 | Bit 16 empties both FIFOs, bits 15:8 high watermark, bits 7:0 low watermark |
| ctl_thr | output | 16 | Watermark readback, high in 15:8 and low in 7:0 |
| fifo_level | output | 8 | Fill level of the selected FIFO |
| eng_nack | input | 1 | Engine condition: address not acknowledged |
| eng_sack | input | 1 | Engine condition: address acknowledged |
| eng_done | input | 1 | Engine condition: data done |
| eng_arb | input | 1 | Engine condition: arbitration lost |
| eng_buserr | input | 1 | Engine condition: bus error |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 32 | New interrupt enable value |
| ist_clr | input | 1 | Status clear write strobe |
| ist_clr_data | input | 32 | Ones mark the status bits to clear |
| int_status | output | 32 | Latched interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reset is held high from time zero until the first clock edges have passed. They also assume that every strobe and engine condition is a clean level sampled at the rising edge, so each rise is seen for exactly one cycle. The bench changes all inputs only at the falling edge and holds them for a full cycle. Engine conditions are raised as single-cycle pulses or held, and stimulus never changes between two rising edges. The random phase alternates fill-biased and drain-biased stretches, so full, empty, overflow and underflow all occur while the model tracks every clear, enable and flush write.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    localparam int DATA_W       = 8;
    localparam int STAT_W       = 32;
    localparam int THR_W        = 8;
    localparam int CTRL_W       = 17;
    localparam int CTRL_RST_BIT = 16;

    // status bit positions (software decodes these)
    localparam int B_NACK   = 25;
    localparam int B_SACK   = 13;
    localparam int B_DONE   = 12;
    localparam int B_ARB    = 11;
    localparam int B_FULL   = 4;
    localparam int B_EMPTY  = 3;
    localparam int B_HIGH   = 2;
    localparam int B_BUSERR = 0;

    localparam logic [STAT_W-1:0] STAT_IMPL =
        (STAT_W'(1) << B_NACK) | (STAT_W'(1) << B_SACK) |
        (STAT_W'(1) << B_DONE) | (STAT_W'(1) << B_ARB)  |
        (STAT_W'(1) << B_FULL) | (STAT_W'(1) << B_EMPTY) |
        (STAT_W'(1) << B_HIGH) | (STAT_W'(1) << B_BUSERR);

    typedef enum logic {
        SRC_TX = 1'b0,
        SRC_RX = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic [THR_W-1:0] hi;
        logic [THR_W-1:0] lo;
    } thr_cfg_t;

    typedef struct packed {
        logic nack;
        logic sack;
        logic done;
        logic arb;
        logic full;
        logic empty;
        logic high;
        logic buserr;
    } cond_t;

    function automatic logic [STAT_W-1:0] cond_to_vec(cond_t c);
        logic [STAT_W-1:0] v;
        v = '0;
        v[B_NACK]   = c.nack;
        v[B_SACK]   = c.sack;
        v[B_DONE]   = c.done;
        v[B_ARB]    = c.arb;
        v[B_FULL]   = c.full;
        v[B_EMPTY]  = c.empty;
        v[B_HIGH]   = c.high;
        v[B_BUSERR] = c.buserr;
        return v;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
// Circular byte store; DEPTH must be a power of two so pointers wrap.
module byte_fifo #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  level
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    logic              is_full, is_empty, do_push, do_pop;

    assign is_full  = (cnt == CNT_W'(DEPTH));
    assign is_empty = (cnt == '0);
    assign do_push  = push & ~is_full & ~flush;
    assign do_pop   = pop & ~is_empty & ~flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + PTR_W'(1);
            if (do_pop)  rp <= rp + PTR_W'(1);
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    assign rdata = mem[rp];
    assign level = cnt;

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (is_full && push && !pop && !flush) |=> (cnt == CNT_W'(DEPTH)) && $stable(rp));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (is_empty && pop && !push && !flush) |=> (cnt == '0) && $stable(rp));

endmodule

// File: rtl/level_flags.sv
module level_flags #(
    parameter int DEPTH = 128,
    parameter int THR_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] level,
    input  logic [THR_W-1:0] hi_thr,
    output logic             full,
    output logic             empty,
    output logic             high
);

    assign full  = (level == CNT_W'(DEPTH));
    assign empty = (level == '0);
    assign high  = (int'(level) >= int'(hi_thr));

endmodule

// File: rtl/irq_stat.sv
module irq_stat #(
    parameter int W = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    input  logic         en_wr,
    input  logic [W-1:0] en_data,
    output logic [W-1:0] status,
    output logic         irq
);

    logic [W-1:0] cond_q, en_q, rise, clr_eff;

    assign rise    = cond & ~cond_q & IMPL;
    assign clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            status <= '0;
            en_q   <= '0;
        end else begin
            cond_q <= cond;
            status <= ((status & ~clr_eff) | rise) & IMPL;
            if (en_wr) en_q <= en_data & IMPL;
        end
    end

    assign irq = |(status & en_q);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((status & $past(rise)) == $past(rise)));

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((status & $past(clr_mask & ~rise)) == '0));

endmodule

// File: rtl/fifo_wmark_irq.sv
module fifo_wmark_irq
    import fwm_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_mode,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_wdata,
    output logic [2*THR_W-1:0] ctl_thr,
    output logic [CNT_W-1:0]  fifo_level,
    input  logic              eng_nack,
    input  logic              eng_sack,
    input  logic              eng_done,
    input  logic              eng_arb,
    input  logic              eng_buserr,
    input  logic              ien_wr,
    input  logic [STAT_W-1:0] ien_wdata,
    input  logic              ist_clr,
    input  logic [STAT_W-1:0] ist_clr_data,
    output logic [STAT_W-1:0] int_status,
    output logic              irq
);

    localparam int NFIFO = 2;

    thr_cfg_t          thr_q;
    logic              flush;
    logic [NFIFO-1:0]  f_push, f_pop;
    logic [DATA_W-1:0] f_wdata [NFIFO];
    logic [DATA_W-1:0] f_rdata [NFIFO];
    logic [CNT_W-1:0]  f_level [NFIFO];
    src_sel_e          sel;
    cond_t             cond;
    logic              lv_full, lv_empty, lv_high;

    // control register: watermarks and FIFO reset strobe
    assign flush = ctl_wr & ctl_wdata[CTRL_RST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q.hi <= THR_W'(DEPTH);
            thr_q.lo <= '0;
        end else if (ctl_wr) begin
            thr_q <= ctl_wdata[2*THR_W-1:0];
        end
    end

    assign ctl_thr = thr_q;

    // FIFO pair
    assign f_push     = {rx_push, tx_push};
    assign f_pop      = {rx_pop, tx_pop};
    assign f_wdata[0] = tx_wdata;
    assign f_wdata[1] = rx_wdata;

    for (genvar g = 0; g < NFIFO; g++) begin : g_fifo
        byte_fifo #(
            .DEPTH (DEPTH),
            .DATA_W(DATA_W)
        ) u_fifo (
            .clk  (clk),
            .rst  (rst),
            .flush(flush),
            .push (f_push[g]),
            .wdata(f_wdata[g]),
            .pop  (f_pop[g]),
            .rdata(f_rdata[g]),
            .level(f_level[g])
        );
    end

    assign tx_rdata = f_rdata[0];
    assign rx_rdata = f_rdata[1];

    // direction select for level and level events
    assign sel        = src_sel_e'(rd_mode);
    assign fifo_level = (sel == SRC_RX) ? f_level[1] : f_level[0];

    level_flags #(
        .DEPTH(DEPTH),
        .THR_W(THR_W)
    ) u_flags (
        .level (fifo_level),
        .hi_thr(thr_q.hi),
        .full  (lv_full),
        .empty (lv_empty),
        .high  (lv_high)
    );

    always_comb begin
        cond.nack   = eng_nack;
        cond.sack   = eng_sack;
        cond.done   = eng_done;
        cond.arb    = eng_arb;
        cond.full   = lv_full;
        cond.empty  = lv_empty;
        cond.high   = lv_high;
        cond.buserr = eng_buserr;
    end

    irq_stat #(
        .W   (STAT_W),
        .IMPL(STAT_IMPL)
    ) u_stat (
        .clk     (clk),
        .rst     (rst),
        .cond    (cond_to_vec(cond)),
        .clr_wr  (ist_clr),
        .clr_mask(ist_clr_data),
        .en_wr   (ien_wr),
        .en_data (ien_wdata),
        .status  (int_status),
        .irq     (irq)
    );

    // R4
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fifo_level == '0));

    // R4
    thr_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_thr == $past(ctl_wdata[2*THR_W-1:0])));

endmodule

// File: tb/fifo_wmark_irq_tb_top.sv
`timescale 1ns/1ps
module fifo_wmark_irq_tb_top;

    localparam int DEPTH = 128;
    localparam logic [31:0] IMPL = 32'h0200_381D; // bits 25,13,12,11,4,3,2,0

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_mode = 1'b0;
    logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic ctl_wr = 1'b0;
    logic [16:0] ctl_wdata = '0;
    logic [15:0] ctl_thr;
    logic [7:0] fifo_level;
    logic eng_nack = 0, eng_sack = 0, eng_done = 0, eng_arb = 0, eng_buserr = 0;
    logic ien_wr = 1'b0, ist_clr = 1'b0;
    logic [31:0] ien_wdata = '0, ist_clr_data = '0, int_status;
    logic irq;

    always #2 clk = ~clk;

    fifo_wmark_irq #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .rd_mode(rd_mode),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_thr(ctl_thr), .fifo_level(fifo_level),
        .eng_nack(eng_nack), .eng_sack(eng_sack), .eng_done(eng_done), .eng_arb(eng_arb),
        .eng_buserr(eng_buserr), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .ist_clr(ist_clr), .ist_clr_data(ist_clr_data), .int_status(int_status), .irq(irq)
    );

    // reference model state
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    int m_hi = 128, m_lo = 0;
    logic [31:0] m_stat = '0, m_en = '0, m_condq = '0;
    int n_chk = 0, n_bad = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int sel_level();
        return rd_mode ? rx_q.size() : tx_q.size();
    endfunction

    task automatic model_edge();
        logic [31:0] cond, rise, clr;
        int lvl;
        bit fl, tpush, tpop, rpush, rpop;
        if (rst) begin
            tx_q.delete(); rx_q.delete();
            m_stat = '0; m_en = '0; m_condq = '0; m_hi = 128; m_lo = 0;
            return;
        end
        lvl = sel_level();
        cond = '0;
        cond[25] = eng_nack; cond[13] = eng_sack; cond[12] = eng_done;
        cond[11] = eng_arb;  cond[0]  = eng_buserr;
        cond[4]  = (lvl == DEPTH);
        cond[3]  = (lvl == 0);
        cond[2]  = (lvl >= m_hi);
        rise = cond & ~m_condq;
        clr = ist_clr ? ist_clr_data : 32'h0;
        m_stat = ((m_stat & ~clr) | rise) & IMPL;
        m_condq = cond;
        if (ien_wr) m_en = ien_wdata & IMPL;
        fl = ctl_wr && ctl_wdata[16];
        if (ctl_wr) begin
            m_hi = int'(ctl_wdata[15:8]);
            m_lo = int'(ctl_wdata[7:0]);
        end
        if (fl) begin
            tx_q.delete(); rx_q.delete();
        end else begin
            tpush = tx_push && tx_q.size() < DEPTH;
            tpop  = tx_pop && tx_q.size() > 0;
            rpush = rx_push && rx_q.size() < DEPTH;
            rpop  = rx_pop && rx_q.size() > 0;
            if (tpop) void'(tx_q.pop_front());
            if (tpush) tx_q.push_back(tx_wdata);
            if (rpop) void'(rx_q.pop_front());
            if (rpush) rx_q.push_back(rx_wdata);
        end
    endtask

    task automatic compare_all();
        check("R3 level", 32'(fifo_level), 32'(sel_level()));
        if (tx_q.size() > 0) check("R1 tx head", 32'(tx_rdata), 32'(tx_q[0]));
        if (rx_q.size() > 0) check("R1 rx head", 32'(rx_rdata), 32'(rx_q[0]));
        check("R4 thr readback", 32'(ctl_thr), (32'(m_hi) << 8) | 32'(m_lo));
        check("R6 status", int_status, m_stat);
        check("R10 irq", 32'(irq), 32'(|(m_stat & m_en)));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic strobes_off();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; ctl_wr = 0;
        ien_wr = 0; ist_clr = 0;
        eng_nack = 0; eng_sack = 0; eng_done = 0; eng_arb = 0; eng_buserr = 0;
    endtask

    task automatic clear_all_status();
        ist_clr = 1; ist_clr_data = 32'hFFFF_FFFF;
        step();
        ist_clr = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        // R11 reset state
        check("R11 level", 32'(fifo_level), 32'd0);
        check("R11 status", int_status, 32'd0);
        check("R11 irq", 32'(irq), 32'd0);
        check("R11 thr", 32'(ctl_thr), 32'h0000_8000);

        rst = 0;
        step();
        // R6 empty true in first cycle after reset latches (bit 3), enable still 0
        check("R6 empty after reset", int_status, 32'h0000_0008);
        check("R10 irq disabled", 32'(irq), 32'd0);

        ien_wr = 1; ien_wdata = 32'hFFFF_FFFF;
        step();
        ien_wr = 0;
        check("R10 irq enabled", 32'(irq), 32'd1);

        // R8 write back what was read
        ist_clr = 1; ist_clr_data = int_status;
        step();
        ist_clr = 0;
        check("R8 w1c read value", int_status, 32'd0);
        repeat (3) step();
        check("R6 held condition no reset", int_status, 32'd0);

        // watermark hi=4, lo=2
        ctl_wr = 1; ctl_wdata = 17'h0_0402;
        step();
        ctl_wr = 0;
        check("R4 thr loaded", 32'(ctl_thr), 32'h0000_0402);
        for (int i = 0; i < 4; i++) begin
            tx_push = 1; tx_wdata = 8'(i + 8'h10);
            step();
        end
        tx_push = 0;
        step();
        check("R7 high at level 4", 32'(int_status[2]), 32'd1);
        check("R1 oldest byte", 32'(tx_rdata), 32'h10);
        clear_all_status();

        // fill past full
        for (int i = 0; i < 130; i++) begin
            tx_push = 1; tx_wdata = 8'(i);
            step();
        end
        tx_push = 0;
        check("R2 level capped", 32'(fifo_level), 32'd128);
        step();
        check("R7 full latched", 32'(int_status[4]), 32'd1);
        check("R5 full bit only fifo bits", int_status & 32'hFFFF_FFE3, 32'd0);
        // push+pop when full: only pop
        tx_push = 1; tx_pop = 1; tx_wdata = 8'hEE;
        step();
        strobes_off();
        check("R2 full push pop", 32'(fifo_level), 32'd127);

        // drain and underflow
        for (int i = 0; i < 130; i++) begin
            tx_pop = 1;
            step();
        end
        tx_pop = 0;
        check("R2 empty pop ignored", 32'(fifo_level), 32'd0);

        // receive side
        rd_mode = 1;
        clear_all_status();
        for (int i = 0; i < 6; i++) begin
            rx_push = 1; rx_wdata = 8'(8'hA0 + i);
            rx_pop = (i % 2 == 1);
            step();
        end
        strobes_off();
        check("R3 rx level", 32'(fifo_level), 32'd3);
        check("R1 rx order", 32'(rx_rdata), 32'hA3);

        // flush with same-cycle push
        ctl_wr = 1; ctl_wdata = 17'h1_0800; rx_push = 1; tx_push = 1;
        step();
        strobes_off();
        check("R4 flush empties", 32'(fifo_level), 32'd0);
        rd_mode = 0;
        step();
        check("R4 flush empties tx", 32'(fifo_level), 32'd0);
        rd_mode = 1;
        clear_all_status();

        // engine events
        eng_nack = 1;
        step();
        eng_nack = 0;
        step();
        check("R5 nack bit 25", int_status, 32'h0200_0000);
        clear_all_status();
        eng_arb = 1; ist_clr = 1; ist_clr_data = 32'h0000_0800;
        step();
        strobes_off();
        check("R9 set wins", int_status, 32'h0000_0800);
        clear_all_status();

        // selective enable
        ien_wr = 1; ien_wdata = 32'h0000_1000;
        eng_sack = 1;
        step();
        strobes_off();
        step();
        check("R10 not enabled bit", 32'(irq), 32'd0);
        eng_done = 1;
        step();
        eng_done = 0;
        check("R10 enabled bit", 32'(irq), 32'd1);
        check("R5 sack and done", int_status & 32'h0000_3000, 32'h0000_3000);

        // random phase
        for (int c = 0; c < 3000; c++) begin
            bit fillp;
            fillp = ((c / 300) % 2) == 0;
            tx_push = fillp ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
            tx_pop  = fillp ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
            rx_push = fillp ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
            rx_pop  = fillp ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
            tx_wdata = 8'($urandom); rx_wdata = 8'($urandom);
            if ($urandom % 64 == 0) rd_mode = ~rd_mode;
            eng_nack = ($urandom % 16 == 0); eng_sack = ($urandom % 16 == 0);
            eng_done = ($urandom % 16 == 0); eng_arb = ($urandom % 16 == 0);
            eng_buserr = ($urandom % 16 == 0);
            ist_clr = ($urandom % 4 == 0);
            ist_clr_data = ($urandom % 2) ? int_status : $urandom;
            ien_wr = ($urandom % 32 == 0); ien_wdata = $urandom;
            ctl_wr = ($urandom % 40 == 0);
            ctl_wdata = {($urandom % 8 == 0) ? 1'b1 : 1'b0, 8'($urandom % 140), 8'($urandom)};
            step();
        end
        strobes_off();
        step();
        finish_run();
    end

endmodule